// File: doc/BRIEF.md
# DRAM Address Bus Output Stage

This block sits between command issue logic and the DRAM address pads. Every clock it receives one command cycle, either valid (strobe high, with an address and a bank) or idle. It registers two copies of the address onto the bus. The true copy carries the address as issued. The balanced copy is normally the bit-wise inverse of the true copy, so the total switching on the bus stays level.

During idle cycles the stage can either hold the address of the last valid command, which cuts toggling on the bus, or return the bus to a neutral value. Static control inputs set four things: whether hold is used, whether balancing is used, whether A0 is left out of balancing (needed by DRAMs programmed for sequential burst order), and whether the command/address pins are driven at all.

Top module: `ca_bus_stage`

## Requirements
- R1: With `hold_off` low, an idle cycle that follows a valid command leaves `addr_q` and `bank_q` at the values of that last valid command. Across a run of idle cycles they stay at the last valid command's values.
- R2: With `hold_off` high, an idle cycle drives `addr_q` and `bank_q` to all zeros on the next clock.
- R3: A valid cycle (`cmd_valid` high) puts `cmd_addr` on `addr_q` and `cmd_bank` on `bank_q` one clock later.
- R4: With `bal_off` low, bits ADDR_W-1..1 of `addr_bal_q` are the inverse of the same bits of `addr_q` in every cycle after reset. As a result, an idle cycle with `hold_off` high gives ones on those bits.
- R5: With `bal_off` high, `addr_bal_q` equals `addr_q` on all bits, including the all-zero idle value. `bal_off` takes priority over `a0_bal_off`.
- R6: With `bal_off` low, `addr_bal_q[0]` equals `addr_q[0]` when `a0_bal_off` is high, and is its inverse when `a0_bal_off` is low.
- R7: `ca_oe` equals the inverse of `ca_off` sampled one clock earlier. `addr_q`, `bank_q` and `addr_bal_q` keep updating while `ca_oe` is low.
- R8: After reset, `addr_q` and `bank_q` are all zeros, `addr_bal_q` is all ones and `ca_oe` is low. The held value is cleared, so idle cycles with hold enabled keep the outputs at zero until the first valid command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | High for a valid command cycle, low for an idle cycle |
| cmd_addr | input | ADDR_W | Address of the command cycle |
| cmd_bank | input | BANK_W | Bank address of the command cycle |
| hold_off | input | 1 | High disables holding the address through idle cycles |
| bal_off | input | 1 | High disables the balanced (inverted) copy |
| a0_bal_off | input | 1 | High excludes A0 from balancing |
| ca_off | input | 1 | High disables the command/address outputs |
| addr_q | output | ADDR_W | Registered true address copy |
| bank_q | output | BANK_W | Registered bank address |
| addr_bal_q | output | ADDR_W | Registered balanced address copy |
| ca_oe | output | 1 | Registered output enable for the command/address pins |

## Verification
The bench first goes after the hold path. A design that copies the idle-cycle input instead of the held command would show garbage on the bus. A design that forgets the held value after a hold-off idle would bring back zero once hold is enabled again, and a design that fails to clear the held value at reset would show stale data. Next it covers the A0 exception in both polarities and in combination with full balance disable. An inverted mask, or letting the A0 rule override the disable, shows up as a mismatch on bit 0 alone. Finally, it toggles the output disable with traffic still flowing. A stage that froze its data while tri-stated, or that applied the enable with the wrong latency, would diverge from the reference model.

// File: rtl/ca_bus_stage.sv
module ca_bus_stage #(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              hold_off,
  input  logic              bal_off,
  input  logic              a0_bal_off,
  input  logic              ca_off,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [ADDR_W-1:0] addr_bal_q,
  output logic              ca_oe
);

  localparam logic [ADDR_W-1:0] A0_MASK = ADDR_W'(1);

  logic [ADDR_W-1:0] held_addr, addr_nx, inv_mask;
  logic [BANK_W-1:0] held_bank, bank_nx;

  assign addr_nx  = cmd_valid ? cmd_addr : (hold_off ? '0 : held_addr);
  assign bank_nx  = cmd_valid ? cmd_bank : (hold_off ? '0 : held_bank);
  assign inv_mask = bal_off ? '0 : (a0_bal_off ? ~A0_MASK : '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_addr  <= '0;
      held_bank  <= '0;
      addr_q     <= '0;
      bank_q     <= '0;
      addr_bal_q <= '1;
      ca_oe      <= 1'b0;
    end else begin
      if (cmd_valid) begin
        held_addr <= cmd_addr;
        held_bank <= cmd_bank;
      end
      addr_q     <= addr_nx;
      bank_q     <= bank_nx;
      addr_bal_q <= addr_nx ^ inv_mask;
      ca_oe      <= ~ca_off;
    end
  end

endmodule

module ca_bus_stage_chk #(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              hold_off,
  input logic              bal_off,
  input logic              a0_bal_off,
  input logic              ca_off,
  input logic [ADDR_W-1:0] addr_q,
  input logic [BANK_W-1:0] bank_q,
  input logic [ADDR_W-1:0] addr_bal_q,
  input logic              ca_oe
);

  p_hold_after_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_valid) && !cmd_valid && !hold_off) |=>
      (addr_q == $past(addr_q) && bank_q == $past(bank_q)));

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && hold_off) |=> (addr_q == '0 && bank_q == '0));

  p_cmd_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (addr_q == $past(cmd_addr) && bank_q == $past(cmd_bank)));

  p_bal_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bal_off |=> (addr_bal_q[ADDR_W-1:1] == ~addr_q[ADDR_W-1:1]));

  p_bal_off_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bal_off |=> (addr_bal_q == addr_q));

  p_a0_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bal_off && a0_bal_off) |=> (addr_bal_q[0] == addr_q[0]));

  p_a0_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bal_off && !a0_bal_off) |=> (addr_bal_q[0] != addr_q[0]));

  p_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ca_oe == !$past(ca_off)));

  p_reset_r8: assert property (@(posedge clk)
    !rst_n |=> (addr_q == '0 && bank_q == '0 && addr_bal_q == '1 && !ca_oe));

endmodule

bind ca_bus_stage ca_bus_stage_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_chk (.*);

// File: tb/test_ca_bus_stage.sv
module test_ca_bus_stage;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 14;
  localparam int BW = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, hold_off = 0, bal_off = 0, a0_bal_off = 0, ca_off = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [BW-1:0] cmd_bank = '0;
  logic [AW-1:0] addr_q, addr_bal_q;
  logic [BW-1:0] bank_q;
  logic ca_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  ca_bus_stage #(.ADDR_W(AW), .BANK_W(BW)) i_ca_bus_stage (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int unsigned last_a = 0, last_b = 0, e_a = 0, e_b = 0, e_bal = 16383, e_oe = 0;
  string req_a = "R8", req_b = "R8", req_oe = "R8";

  always @(posedge clk) begin
    if (!rst_n) begin
      last_a = 0; last_b = 0; e_a = 0; e_b = 0; e_bal = (1 << AW) - 1; e_oe = 0;
      req_a = "R8"; req_b = "R8"; req_oe = "R8";
    end else begin
      if (cmd_valid) begin
        last_a = cmd_addr; last_b = cmd_bank; e_a = cmd_addr; e_b = cmd_bank; req_a = "R3";
      end else if (hold_off) begin
        e_a = 0; e_b = 0; req_a = "R2";
      end else begin
        e_a = last_a; e_b = last_b; req_a = "R1";
      end
      if (bal_off) begin
        e_bal = e_a; req_b = "R5";
      end else begin
        e_bal = e_a ^ ((1 << AW) - 1);
        if (a0_bal_off) e_bal = e_bal ^ 1;
        req_b = a0_bal_off ? "R6" : "R4";
      end
      e_oe = ca_off ? 0 : 1; req_oe = "R7";
    end
  end

  task automatic chk(string r, int unsigned act, int unsigned exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic cyc(bit v, int unsigned a, int unsigned b, bit ho, bit bo, bit a0o, bit co);
    @(negedge clk);
    chk(req_a, addr_q, e_a, "addr_q");
    chk(req_a, bank_q, e_b, "bank_q");
    chk(req_b, addr_bal_q, e_bal, "addr_bal_q");
    chk(req_oe, ca_oe, e_oe, "ca_oe");
    cmd_valid = v; cmd_addr = AW'(a); cmd_bank = BW'(b);
    hold_off = ho; bal_off = bo; a0_bal_off = a0o; ca_off = co;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset state, then idle with hold keeps zero
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 16'h1234, 5, 0, 0, 0, 0);
    cyc(0, 16'h0fff, 7, 0, 0, 0, 0);
    // R3 / R1: commands then held idles
    cyc(1, 14'h2a55, 3, 0, 0, 0, 0);
    cyc(0, 14'h1111, 1, 0, 0, 0, 0);
    cyc(0, 14'h0001, 6, 0, 0, 0, 0);
    cyc(1, 14'h3fff, 7, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    // R2: hold off idles, then hold back on recalls last command (R1)
    cyc(0, 14'h0abc, 2, 1, 0, 0, 0);
    cyc(0, 14'h0abc, 2, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    // R6: A0 excluded
    cyc(1, 14'h0001, 1, 0, 0, 1, 0);
    cyc(1, 14'h0002, 1, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0, 1, 0);
    // R5: balancing off, A0 flag ignored
    cyc(1, 14'h1357, 4, 0, 1, 1, 0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    // R7: outputs disabled while traffic flows
    cyc(1, 14'h2222, 2, 0, 0, 0, 1);
    cyc(1, 14'h0444, 6, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++)
      cyc($urandom_range(0, 1), $urandom, $urandom, $urandom_range(0, 1),
          ($urandom_range(0, 3) == 0), $urandom_range(0, 1), ($urandom_range(0, 4) == 0));
    // R8: reset mid-stream clears held value
    cyc(1, 14'h3333, 3, 0, 0, 0, 0);
    rst_n = 0;
    cyc(0, 0, 0, 0, 0, 0, 0);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule